// File: doc/BRIEF.md
# Programmable Scale-Factor Delay Counter

This block measures out a time delay as a count of timebase ticks. A 3-bit range code picks one of eight tick counts. The ladder is not uniform: decade steps are mixed with ×60 and ×3600 multipliers, so the eight ranges cover tenths of a second through to an hour on a 10 kHz timebase. A start request captures the range code and loads the counter. The count then drops by one on each cycle where the tick enable from the timebase oscillator is high. When the last tick arrives, the block raises a one-cycle done pulse and clears busy.

A start request while a run is in progress throws away the elapsed count and begins a fresh full delay. An abort request stops the run silently. A synchronous master clear overrides both. The block also exports a short-range flag for the latched code. A neighbouring flash-indicator block uses this flag to choose its pulse rate. Everything runs in one clock domain.

Top module: `delay_scaler`

## Requirements
- R1: The range code selects the loaded tick count S as follows, for the default unit of 1000: code 0 → 1,000; 1 → 10,000; 2 → 100,000; 3 → 60,000; 4 → 600,000; 5 → 6,000,000; 6 → 3,600,000; 7 → 36,000,000. The counter is 26 bits wide.
- R2: Done is high for exactly one cycle. It rises after the clock edge that takes the S-th tick following the load, and busy falls at that same edge.
- R3: The range code is captured only when a start is accepted. Changing `range_sel` during a run changes neither the delay nor the short-range flag.
- R4: A start accepted while busy reloads the full count S of the newly sampled code. If that start lands on the edge of the final tick, no done pulse is produced, and the next done follows S ticks later.
- R5: Abort clears the count and busy at the next edge and produces no done pulse. When abort and start are high in the same cycle, abort wins and no run begins.
- R6: `short_range` is 1 while the latched code is 0 or 1, and 0 for codes 2 to 7.
- R7: The count drops only on cycles where `tick_en` is high. A tick on the load cycle itself is not counted, and while `tick_en` is low a run stays busy without ending.
- R8: The master clear `clr` has priority over start and abort. After `clr` or the asynchronous reset, busy is 0, done is 0, and the latched code is 7, so `short_range` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous master clear, highest priority |
| start | input | 1 | Start or restart a timing run |
| abort | input | 1 | Cancel a run without a done pulse |
| tick_en | input | 1 | Timebase tick, one-cycle clock enable |
| range_sel | input | 3 | Range code sampled at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at timeout |
| short_range | output | 1 | Latched code is one of the two shortest ranges |

## Verification
Reload and timeout can fall on the same edge. A restart request is placed exactly on the cycle that carries the final tick of a running delay. The scoreboard must then see no done at that edge, and a single done exactly S ticks after the restart. Abort against start, and clear against start, are also driven in the same cycle, and each is judged by busy and the short-range flag on the following cycle.

// File: rtl/dly_pkg.sv
package dly_pkg;

  localparam int unsigned CODE_W = 3;

  // Range multiplier ladder: decade steps mixed with x60 and x3600 steps.
  function automatic longint unsigned range_mult(input logic [CODE_W-1:0] code);
    longint unsigned m;
    case (code)
      3'd0:    m = 1;
      3'd1:    m = 10;
      3'd2:    m = 100;
      3'd3:    m = 60;
      3'd4:    m = 600;
      3'd5:    m = 6000;
      3'd6:    m = 3600;
      default: m = 36000;
    endcase
    return m;
  endfunction

  // Number of ticks a run lasts for a given code and base unit.
  function automatic longint unsigned scale_ticks(input logic [CODE_W-1:0] code,
                                                  input int unsigned unit);
    return range_mult(code) * longint'(unit);
  endfunction

endpackage

// File: rtl/dly_code_latch.sv
module dly_code_latch #(
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned SHORT_CODES = 2,
  parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  output logic              short_range
);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= IDLE_CODE;
    end else if (clr) begin
      code_q <= IDLE_CODE;
    end else if (capture) begin
      code_q <= code_in;
    end
  end

  assign short_range = (32'(code_q) < SHORT_CODES);

  // R3: the latched code only moves on capture or clear
  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clr) |=> $stable(code_q));

  // R6: after a capture the flag reflects the captured code
  p_short_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clr) |=> (short_range == (32'($past(code_in)) < SHORT_CODES)));

endmodule

// File: rtl/dly_down_counter.sv
module dly_down_counter #(
  parameter int unsigned CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             kill,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             last_step;

  assign step      = busy && tick && !clr && !kill && !load;
  assign last_step = step && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_step;
      if (clr || kill) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else if (load) begin
        cnt  <= load_val;
        busy <= 1'b1;
      end else if (step) begin
        cnt <= cnt - CNT_W'(1);
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // R4: a load restarts with the full count
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && cnt == $past(load_val)));

  // R7: without a tick the count and busy hold
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !load && !kill && !clr) |=> ($stable(cnt) && busy));

  // R2: done coincides with busy low and lasts one cycle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5 / R8: abort or clear leaves the counter idle and silent
  p_kill_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill || clr) |=> (!busy && !done && cnt == '0));

endmodule

// File: rtl/delay_scaler.sv
module delay_scaler #(
  parameter int unsigned TICK_UNIT = 1000,
  parameter int unsigned CNT_W     = 26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  logic       abort,
  input  logic       tick_en,
  input  logic [2:0] range_sel,
  output logic       busy,
  output logic       done,
  output logic       short_range
);

  import dly_pkg::*;

  logic             accept_start;
  logic [CNT_W-1:0] full_count;

  // Clear beats abort, abort beats start.
  assign accept_start = start && !abort && !clr;
  assign full_count   = CNT_W'(scale_ticks(range_sel, TICK_UNIT));

  dly_code_latch #(
    .CODE_W     (CODE_W),
    .SHORT_CODES(2),
    .IDLE_CODE  ('1)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .capture    (accept_start),
    .code_in    (range_sel),
    .short_range(short_range)
  );

  dly_down_counter #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (accept_start),
    .kill    (abort),
    .tick    (tick_en),
    .load_val(full_count),
    .busy    (busy),
    .done    (done)
  );

  // R8: clear wins over a simultaneous start
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && start) |=> (!busy && !short_range));

  // R5: abort wins over a simultaneous start
  p_abort_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && start) |=> !busy);

endmodule

// File: tb/delay_scaler_tb.sv
`timescale 1ns/1ps
module delay_scaler_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic       tick_en = 1'b1;
  logic [2:0] range_sel = 3'd0;
  logic       busy, done, short_range;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  delay_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .abort(abort),
    .tick_en(tick_en), .range_sel(range_sel),
    .busy(busy), .done(done), .short_range(short_range)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Expected tick counts, restated from the requirement table (R1).
  function automatic int ticks_for(input int code);
    int t[8] = '{1000, 10000, 100000, 60000, 600000, 6000000, 3600000, 36000000};
    return t[code];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected done cycles from the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !finished && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R4/R5 unexpected done", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R1/R2 done cycle", cyc, e);
        chk(busy == 1'b0, "R2 busy low with done", busy, 0);
      end
    end
  end

  task automatic drive_edge();
    @(negedge clk);
    #1;
  endtask

  // Driver: starts a run and pushes the expected done cycle.
  task automatic start_run(input int code, input bit push);
    drive_edge();
    exp_q.delete();
    range_sel = 3'(code);
    start = 1'b1;
    if (push) exp_q.push_back(cyc + 1 + ticks_for(code));
    drive_edge();
    start = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && (busy || exp_q.size() != 0); i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 pending done delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive_edge();
    // R8: reset state
    chk(busy == 0, "R8 reset busy", busy, 0);
    chk(done == 0, "R8 reset done", done, 0);
    chk(short_range == 0, "R8 reset short flag", short_range, 0);

    // R1, R2, R6: shortest range
    start_run(0, 1);
    chk(busy == 1, "R2 busy during run", busy, 1);
    chk(short_range == 1, "R6 short flag code 0", short_range, 1);
    wait_idle(2000);

    // R3: changing the selector mid-run is ignored
    start_run(1, 1);
    repeat (10) @(negedge clk);
    #1 range_sel = 3'd7;
    repeat (3) @(negedge clk);
    chk(short_range == 1, "R3 R6 flag kept after selector change", short_range, 1);
    wait_idle(12000);

    // R1, R6: x60 range
    start_run(3, 1);
    chk(short_range == 0, "R6 short flag code 3", short_range, 0);
    wait_idle(62000);

    // R4: restart mid-run
    start_run(0, 1);
    repeat (500) @(negedge clk);
    start_run(0, 1);
    wait_idle(2000);

    // R4: restart on the very edge of the final tick
    begin
      int e;
      start_run(0, 1);
      e = exp_q[0];
      while (cyc != e - 1) @(negedge clk);
      #1;
      exp_q.delete();
      start = 1'b1;
      exp_q.push_back(cyc + 1 + ticks_for(0));
      drive_edge();
      start = 1'b0;
      chk(busy == 1, "R4 restart at timeout keeps busy", busy, 1);
      wait_idle(2000);
    end

    // R5: abort mid-run, no done afterwards
    start_run(0, 0);
    repeat (100) @(negedge clk);
    #1 abort = 1'b1;
    drive_edge();
    abort = 1'b0;
    chk(busy == 0, "R5 abort clears busy", busy, 0);
    repeat (1500) @(negedge clk);
    chk(busy == 0, "R5 stays idle after abort", busy, 0);

    // R5: abort beats a simultaneous start
    drive_edge();
    range_sel = 3'd0; start = 1'b1; abort = 1'b1;
    drive_edge();
    start = 1'b0; abort = 1'b0;
    chk(busy == 0, "R5 abort wins over start", busy, 0);

    // R7: no decrement without ticks
    drive_edge();
    tick_en = 1'b0;
    start_run(0, 0);
    repeat (2000) @(negedge clk);
    chk(busy == 1, "R7 busy held without ticks", busy, 1);
    #1;
    exp_q.push_back(cyc + ticks_for(0));
    tick_en = 1'b1;
    wait_idle(2000);

    // R1: longest range still running well past shorter ranges
    start_run(7, 0);
    repeat (3000) @(negedge clk);
    chk(busy == 1, "R1 code 7 still busy", busy, 1);
    chk(short_range == 0, "R6 short flag code 7", short_range, 0);

    // R8: clear beats a simultaneous start
    start_run(1, 0);
    chk(short_range == 1, "R6 short flag code 1", short_range, 1);
    drive_edge();
    clr = 1'b1; start = 1'b1; range_sel = 3'd0;
    drive_edge();
    clr = 1'b0; start = 1'b0;
    chk(busy == 0, "R8 clear idles counter", busy, 0);
    chk(short_range == 0, "R8 clear resets latched code", short_range, 0);
    repeat (1500) @(negedge clk);
    chk(done == 0 && busy == 0, "R8 no done after clear", done, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule